// File: doc/BRIEF.md
# Quadrature Tone-Pair Downconverter

This block shifts a real audio-band sample stream down to baseband around the centre of a frequency-shift-keyed tone pair. Samples arrive at a fixed 200 kHz rate as signed words, each marked by a valid strobe. A phase-accumulator oscillator is tuned to the midpoint of the two tones, halfway between the mark and space frequencies. Each accepted sample is multiplied by the oscillator's cosine and by its negated sine. The results are the in-phase and quadrature products of a complex downconversion.

With the oscillator at the midpoint, tones 400 Hz apart leave the mixer at -200 Hz and +200 Hz. A later low-pass stage separates them from the second image, which sits near minus twice the oscillator frequency. The tone pair may lie anywhere from about 3 kHz to 20 kHz. The tuning word for a centre frequency fc is round(fc * 2^32 / 200000). For example, a 4050/4450 Hz pair uses fc = 4250 Hz, which gives 91268055. The I and Q products leave on separate outputs, one for each downstream filter branch. They share a single valid strobe.

Top module: `tone_pair_mixer`

## Requirements
- R1: While rst_ni is low, vld_o, i_o and q_o are 0 and the phase accumulator is cleared to 0. The first valid sample after reset is therefore mixed at phase 0.
- R2: vld_o equals sample_vld_i as it was two clock cycles earlier.
- R3: i_o = (x*c + 2^14) >>> 15, with the arithmetic shift taken on the full-width product. Here x is the sample and c is the cosine table value at the sample's phase. The result always lies within -32767..32767.
- R4: q_o = (x*s + 2^14) >>> 15, where s is the negated sine table value at the sample's phase.
- R5: Let p be the top 10 bits of the 32-bit phase. Let T[k] = round(32767*sin(2*pi*(k+0.5)/1024)) for k = 0..255. Then sin(p) is defined as follows. Bits p[9:8] select the quadrant and p[7:0] is the index i. The quadrant values 0, 1, 2 and 3 give T[i], T[255-i], -T[i] and -T[255-i] in that order. cos(p) is defined as sin(p+256 mod 1024).
- R6: On each clock with sample_vld_i high, the accumulator adds tune_i. It does not change on any other cycle, so changes to tune_i between samples have no effect.
- R7: A change of tune_i never resets the phase. The next sample continues from the accumulated phase.
- R8: The phase accumulator wraps modulo 2^32.
- R9: When vld_o is low, i_o and q_o hold the values they had on the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_vld_i | input | 1 | Marks a valid input sample |
| sample_i | input | 16 | Signed real input sample |
| tune_i | input | 32 | Phase step per sample (oscillator tuning word) |
| i_o | output | 16 | Signed in-phase product |
| q_o | output | 16 | Signed quadrature product |
| vld_o | output | 1 | Marks valid i_o/q_o, two cycles after the input |

## Verification
The hardest case to reach from the ports is a retune between sparse samples. Here tune_i changes on idle cycles, and any premature use of it would shift the phase of every later product. The random stimulus therefore inserts idle gaps of random length and changes tune_i inside them. This is mixed with directed runs that do three things: step through every table address across all four quadrants, drive a large step that wraps the accumulator, and apply full-scale positive and negative samples.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
  localparam int LO_AMP_W = 16;

  typedef struct packed {
    logic signed [LO_AMP_W-1:0] c;
    logic signed [LO_AMP_W-1:0] ns;
  } lo_t;
endpackage

// File: rtl/nco_accum.sv
module nco_accum #(
  parameter int PHASE_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_en_i,
  input  logic [PHASE_W-1:0] tune_i,
  output logic [PHASE_W-1:0] phase_o
);
  // wraps naturally modulo 2^PHASE_W
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        phase_o <= '0;
    else if (step_en_i) phase_o <= phase_o + tune_i;
  end
endmodule

// File: rtl/sincos_lut.sv
module sincos_lut
  import tpm_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] addr_i,
  output lo_t               lo_o
);
  localparam int  QN   = 1 << (ADDR_W - 2);
  localparam int  FULL = 1 << ADDR_W;
  localparam real AMP  = real'((1 << (LO_AMP_W - 1)) - 1);
  localparam real TWO_PI = 6.283185307179586;

  logic [LO_AMP_W-1:0] tab [QN];

  // half-step offset gives exact quarter-wave mirror without an extra entry
  for (genvar k = 0; k < QN; k++) begin : g_tab
    localparam real ANG = TWO_PI * (real'(k) + 0.5) / real'(FULL);
    assign tab[k] = LO_AMP_W'($rtoi(AMP * $sin(ANG) + 0.5));
  end

  logic [ADDR_W-1:0] cos_addr;
  logic [ADDR_W-3:0] s_idx, c_idx;
  logic signed [LO_AMP_W-1:0] s_mag, c_mag;

  always_comb begin
    cos_addr = addr_i + ADDR_W'(QN);
    s_idx    = addr_i[ADDR_W-2] ? ~addr_i[ADDR_W-3:0] : addr_i[ADDR_W-3:0];
    c_idx    = cos_addr[ADDR_W-2] ? ~cos_addr[ADDR_W-3:0] : cos_addr[ADDR_W-3:0];
    s_mag    = $signed(tab[s_idx]);
    c_mag    = $signed(tab[c_idx]);
    // negated sine: positive half of the wave maps to -mag
    lo_o.ns  = addr_i[ADDR_W-1] ? s_mag : -s_mag;
    lo_o.c   = cos_addr[ADDR_W-1] ? -c_mag : c_mag;
  end
endmodule

// File: rtl/mix_round.sv
module mix_round #(
  parameter int DATA_W = 16,
  parameter int AMP_W  = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic signed [DATA_W-1:0] x_i,
  input  logic signed [AMP_W-1:0]  k_i,
  output logic signed [DATA_W-1:0] y_o
);
  localparam int PROD_W = DATA_W + AMP_W;
  localparam int SHIFT  = AMP_W - 1;

  logic signed [PROD_W-1:0] prod, rnd;

  always_comb begin
    prod = PROD_W'(x_i) * PROD_W'(k_i);
    rnd  = prod + (PROD_W'(1) <<< (SHIFT - 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   y_o <= '0;
    else if (en_i) y_o <= rnd[SHIFT +: DATA_W];
  end
endmodule

// File: rtl/tone_pair_mixer.sv
module tone_pair_mixer
  import tpm_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PHASE_W = 32,
  parameter int LUT_AW  = 10
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sample_vld_i,
  input  logic signed [DATA_W-1:0] sample_i,
  input  logic [PHASE_W-1:0]       tune_i,
  output logic signed [DATA_W-1:0] i_o,
  output logic signed [DATA_W-1:0] q_o,
  output logic                     vld_o
);
  logic [PHASE_W-1:0]       phase_w;
  lo_t                      lo_w, lo_q;
  logic signed [DATA_W-1:0] x_q;
  logic                     v1_q;

  nco_accum #(.PHASE_W(PHASE_W)) i_nco (
    .clk_i, .rst_ni,
    .step_en_i (sample_vld_i),
    .tune_i,
    .phase_o   (phase_w)
  );

  sincos_lut #(.ADDR_W(LUT_AW)) i_lut (
    .addr_i (phase_w[PHASE_W-1 -: LUT_AW]),
    .lo_o   (lo_w)
  );

  // stage 1: capture sample with oscillator value of its phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q  <= '0;
      lo_q <= '0;
      v1_q <= 1'b0;
    end else begin
      v1_q <= sample_vld_i;
      if (sample_vld_i) begin
        x_q  <= sample_i;
        lo_q <= lo_w;
      end
    end
  end

  // stage 2: multiply, round, register
  mix_round #(.DATA_W(DATA_W), .AMP_W(LO_AMP_W)) i_mix_i (
    .clk_i, .rst_ni, .en_i(v1_q), .x_i(x_q), .k_i(lo_q.c), .y_o(i_o)
  );

  mix_round #(.DATA_W(DATA_W), .AMP_W(LO_AMP_W)) i_mix_q (
    .clk_i, .rst_ni, .en_i(v1_q), .x_i(x_q), .k_i(lo_q.ns), .y_o(q_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_o <= 1'b0;
    else         vld_o <= v1_q;
  end
endmodule

// File: rtl/tpm_checker.sv
module tpm_checker #(
  parameter int DATA_W  = 16,
  parameter int PHASE_W = 32
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     sample_vld_i,
  input logic signed [DATA_W-1:0] i_o,
  input logic signed [DATA_W-1:0] q_o,
  input logic                     vld_o,
  input logic [PHASE_W-1:0]       phase_i
);
  localparam logic signed [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  p_vld_hi_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_vld_i |-> ##2 vld_o);

  p_vld_lo_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_vld_i |-> ##2 !vld_o);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> ($stable(i_o) && $stable(q_o)));

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (i_o != MOST_NEG) && (q_o != MOST_NEG));

  p_phase_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_vld_i |=> $stable(phase_i));

  always_comb begin
    if (!rst_ni) begin
      a_reset_r1: assert (!vld_o && i_o == '0 && q_o == '0 && phase_i == '0);
    end
  end
endmodule

bind tone_pair_mixer tpm_checker #(.DATA_W(DATA_W), .PHASE_W(PHASE_W)) i_tpm_checker (
  .clk_i, .rst_ni, .sample_vld_i, .i_o, .q_o, .vld_o, .phase_i(phase_w)
);

// File: tb/test_tone_pair_mixer.sv
module test_tone_pair_mixer;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sample_vld_i = 1'b0;
  logic signed [15:0] sample_i = '0;
  logic [31:0] tune_i = '0;
  logic signed [15:0] i_o, q_o;
  logic vld_o;

  always #10 clk_i = ~clk_i;

  tone_pair_mixer i_tone_pair_mixer (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // bench model state
  logic [31:0] ph_m = '0;
  bit   pv [2];
  int   pi_e [2];
  int   pq_e [2];
  string ptag [2];
  int   last_i = 0, last_q = 0;

  function automatic int tab_m(int k);
    real a = 6.283185307179586 * (real'(k) + 0.5) / 1024.0;
    return $rtoi(32767.0 * $sin(a) + 0.5);
  endfunction

  function automatic int sin_m(int p);
    int qd = (p >> 8) & 3;
    int ix = p & 255;
    case (qd)
      0: return tab_m(ix);
      1: return tab_m(255 - ix);
      2: return -tab_m(ix);
      default: return -tab_m(255 - ix);
    endcase
  endfunction

  function automatic int rnd_m(int x, int k);
    longint pr = longint'(x) * longint'(k) + 64'sd16384;
    return int'(pr >>> 15);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  // one cycle: check outputs due now, then drive new inputs
  task automatic step(bit v, int x, logic [31:0] t, string tag);
    @(negedge clk_i);
    chk(vld_o == pv[1], {tag, "/R2 vld"}, int'(vld_o), int'(pv[1]));
    if (pv[1]) begin
      chk(int'(i_o) == pi_e[1], {ptag[1], "/R3 I"}, int'(i_o), pi_e[1]);
      chk(int'(q_o) == pq_e[1], {ptag[1], "/R4 Q"}, int'(q_o), pq_e[1]);
      last_i = pi_e[1];
      last_q = pq_e[1];
    end else begin
      chk(int'(i_o) == last_i, {tag, "/R9 hold I"}, int'(i_o), last_i);
      chk(int'(q_o) == last_q, {tag, "/R9 hold Q"}, int'(q_o), last_q);
    end
    pv[1] = pv[0]; pi_e[1] = pi_e[0]; pq_e[1] = pq_e[0]; ptag[1] = ptag[0];
    sample_vld_i = v;
    sample_i = 16'(x);
    tune_i = t;
    pv[0] = v;
    ptag[0] = tag;
    if (v) begin
      int p = int'(ph_m[31:22]);
      pi_e[0] = rnd_m(x, sin_m((p + 256) & 1023));
      pq_e[0] = rnd_m(x, -sin_m(p));
      ph_m = ph_m + t;
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] t;
    void'($urandom(32'd1234));
    pv[0] = 0; pv[1] = 0;
    ptag[0] = ""; ptag[1] = "";
    repeat (3) @(negedge clk_i);
    chk(vld_o == 1'b0, "R1 reset vld", int'(vld_o), 0);
    chk(i_o == 0 && q_o == 0, "R1 reset data", int'(i_o), 0);
    rst_ni = 1'b1;

    // R1: first sample uses phase 0
    step(1, 20000, 32'd91268055, "R1");
    // midpoint tuning of 4050/4450 Hz pair, full-scale corners
    for (int n = 0; n < 200; n++)
      step(1, (n % 3 == 0) ? 32767 : ((n % 3 == 1) ? -32768 : int'($urandom_range(0, 65535)) - 32768),
           32'd91268055, "R3");
    // R5: walk every table address, full-scale both signs
    for (int n = 0; n < 1024; n++)
      step(1, (n[0]) ? -32768 : 32767, 32'h0040_0000, "R5");
    // R6: random idle gaps, tune changes while idle
    t = 32'd400000000;
    for (int n = 0; n < 300; n++) begin
      bit v = ($urandom_range(0, 2) == 0);
      if (!v) t = $urandom;
      step(v, int'($urandom_range(0, 65535)) - 32768, v ? 32'd95563022 : t, "R6");
    end
    // R7: retune mid-stream without phase reset
    for (int n = 0; n < 100; n++)
      step(1, int'($urandom_range(0, 65535)) - 32768,
           (n < 50) ? 32'd62277025 : 32'd425201762, "R7");
    // R8: large steps that wrap the accumulator
    for (int n = 0; n < 100; n++)
      step(1, int'($urandom_range(0, 65535)) - 32768, 32'hF123_4567, "R8");
    for (int n = 0; n < 4; n++) step(0, 0, 32'hDEAD_BEEF, "R9");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule